// File: doc/BRIEF.md
# SPI Reload Transfer

This block receives a byte from an external SPI master and delivers it into an unrelated system clock domain, where it becomes the reload value of a free-running counter. The serial bits are shifted into a register clocked by the SPI serial clock, and only while the active-low chip select is asserted. Nothing in the system domain uses that register's timing directly.

The system domain watches chip select through a shifter of synchronizing flops. It recognises the release of chip select from a fixed pattern across the shifter and re-registers that decode into a one-cycle load enable. On the cycle after the enable, the reload register copies all bits of the serial register in parallel. The free-running counter counts up every system clock. When it reaches all ones it loads the reload register's current contents instead, so it may pick up an old or a new value at any moment.

Top module: `spi_reload_xfer`

## Requirements
- R1: While `spi_cs_n` is high, rising edges of `spi_sclk` leave the serial register unchanged; a later transfer with no serial clock edges then delivers the previously shifted byte.
- R2: With `spi_cs_n` low, each rising `spi_sclk` edge shifts `spi_mosi` in at bit 0 and moves the older bits up, so the first bit sent ends as bit 7 (MSB first). When more than 8 bits are sent, the last 8 remain.
- R3: After the first system clock edge that samples `spi_cs_n` high following a low period, `load_en` is low after edges 1 to 3 and high after edge 4.
- R4: `load_en` is high for exactly one system clock cycle per chip-select release.
- R5: `reload_value` takes the serial register's byte on the edge after `load_en` is high (edge 5 after release) and holds its value on every other edge.
- R6: When `count_value` is not all ones, it increases by exactly one on each system clock edge.
- R7: When `count_value` is all ones, the next edge loads it with the `reload_value` present before that edge.
- R8: A synchronous active-high `rst` clears `reload_value`, `count_value`, `load_en` and the chip-select synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| load_en | output | 1 | Registered one-cycle reload enable |
| reload_value | output | 8 | Reload register contents |
| count_value | output | 8 | Free-running counter |

## Verification
A byte reaches the system domain only through a fixed chain of registers. The bench therefore releases chip select just after a falling system clock edge, counts the falling edges that follow, and samples at each one. It expects `load_en` after the fourth edge and the new `reload_value` after the fifth, and it checks that neither appears earlier. The counter is checked on every falling edge against the previous sample: either the previous count plus one, or the previously sampled reload value when the count was all ones. That covers both the plain increment and the one-edge reload.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int unsigned DEF_DATA_W      = 8;
    localparam int unsigned DEF_CNT_W       = 8;
    localparam int unsigned DEF_SYNC_STAGES = 4;

    // Release pattern: every stage but the oldest has seen chip select high,
    // the oldest has not yet.
    function automatic logic release_seen(input logic [31:0] chain, input int unsigned stages);
        logic hit;
        hit = ~chain[stages-1];
        for (int unsigned i = 0; i < stages - 1; i++) begin
            hit &= chain[i];
        end
        return hit;
    endfunction

endpackage

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
    parameter int unsigned DATA_W = spi_xfer_pkg::DEF_DATA_W
) (
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic [DATA_W-1:0] shift_data
);

    typedef struct packed {
        logic [DATA_W-1:0] shreg;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cs_n) begin
            st_d.shreg = {st_q.shreg[DATA_W-2:0], mosi};
        end
    end

    always_ff @(posedge sclk) begin
        st_q <= st_d;
    end

    assign shift_data = st_q.shreg;

    AST_SHIFT_IDLE: assert property (@(posedge sclk) disable iff (rst)
        cs_n |=> $stable(st_q.shreg)) else $error("shift while deselected"); // R1

endmodule

// File: rtl/cs_sync_detect.sv
module cs_sync_detect #(
    parameter int unsigned STAGES = spi_xfer_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    output logic match_o,
    output logic load_en_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              en;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        match_w;

    generate
        if (STAGES < 3) begin : g_bad_depth
            initial $error("cs_sync_detect needs at least three stages");
        end
    endgenerate

    always_comb begin
        match_w = spi_xfer_pkg::release_seen(32'(st_q.chain), STAGES);
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], cs_n};
        st_d.en    = match_w;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign match_o   = match_w;
    assign load_en_o = st_q.en;

    AST_MATCH_TO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        match_w |=> st_q.en) else $error("match not re-registered"); // R3
    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        match_w |=> !match_w) else $error("match longer than one cycle"); // R4
    AST_ENABLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        st_q.en |=> !st_q.en) else $error("enable longer than one cycle"); // R4

endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
    parameter int unsigned DATA_W = spi_xfer_pkg::DEF_DATA_W,
    parameter int unsigned CNT_W  = spi_xfer_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] reload_o,
    output logic [CNT_W-1:0]  count_o
);

    localparam logic [CNT_W-1:0] TERMINAL = '1;

    typedef struct packed {
        logic [DATA_W-1:0] reload;
        logic [CNT_W-1:0]  count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.reload = load_data;
        end
        if (st_q.count == TERMINAL) begin
            st_d.count = CNT_W'(st_q.reload);
        end else begin
            st_d.count = st_q.count + 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;

    AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(st_q.reload)) else $error("reload changed without enable"); // R5
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q.count != TERMINAL) |=> (st_q.count == CNT_W'($past(st_q.count) + 1'b1)))
        else $error("counter step wrong"); // R6
    AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (st_q.count == TERMINAL) |=> (st_q.count == CNT_W'($past(st_q.reload))))
        else $error("counter reload wrong"); // R7

endmodule

// File: rtl/spi_reload_xfer.sv
module spi_reload_xfer #(
    parameter int unsigned DATA_W      = spi_xfer_pkg::DEF_DATA_W,
    parameter int unsigned CNT_W       = spi_xfer_pkg::DEF_CNT_W,
    parameter int unsigned SYNC_STAGES = spi_xfer_pkg::DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              load_en,
    output logic [DATA_W-1:0] reload_value,
    output logic [CNT_W-1:0]  count_value
);

    logic [DATA_W-1:0] shift_data;
    logic              match_w;

    spi_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .rst        (rst),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .shift_data (shift_data)
    );

    cs_sync_detect #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (spi_cs_n),
        .match_o   (match_w),
        .load_en_o (load_en)
    );

    reload_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_data (shift_data),
        .reload_o  (reload_value),
        .count_o   (count_value)
    );

    AST_ENABLE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(load_en) |-> $past(match_w)) else $error("enable without match"); // R3

endmodule

// File: tb/spi_reload_xfer_test.sv
module spi_reload_xfer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       load_en;
    logic [7:0] reload_value;
    logic [7:0] count_value;

    int checks = 0;
    int errors = 0;
    logic       mon_on = 1'b0;
    logic [7:0] exp_reload = 8'h00;

    always #2.5 clk = ~clk;

    spi_reload_xfer uut (
        .clk          (clk),
        .rst          (rst),
        .spi_sclk     (spi_sclk),
        .spi_cs_n     (spi_cs_n),
        .spi_mosi     (spi_mosi),
        .load_en      (load_en),
        .reload_value (reload_value),
        .count_value  (count_value)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Counter monitor: compare each falling-edge sample with the previous one.
    logic [7:0] prev_cnt;
    logic [7:0] prev_rel;
    logic       prev_ok = 1'b0;
    always @(negedge clk) begin
        if (mon_on && prev_ok) begin
            if (prev_cnt == 8'hFF)
                chk(count_value == prev_rel, "R7 wrap", count_value, prev_rel);
            else
                chk(count_value == prev_cnt + 8'd1, "R6 step", count_value, prev_cnt + 8'd1);
        end
        prev_cnt = count_value;
        prev_rel = reload_value;
        prev_ok  = mon_on;
    end

    task automatic spi_send(input logic [15:0] bits, input int nbits);
        @(negedge clk);
        spi_cs_n = 1'b0;
        #7;
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_mosi = bits[i];
            #20 spi_sclk = 1'b1;
            #20 spi_sclk = 1'b0;
        end
        #7;
        @(negedge clk);
        spi_cs_n = 1'b1;
    endtask

    // Called right after chip select released at a falling edge.
    task automatic expect_transfer(input logic [7:0] val);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k <= 3)
                chk(load_en == 1'b0, "R3 early", load_en, 0);
            if (k == 4) begin
                chk(load_en == 1'b1, "R3 enable", load_en, 1);
                chk(reload_value == exp_reload, "R5 hold", reload_value, exp_reload);
            end
            if (k == 5) begin
                chk(load_en == 1'b0, "R4 single", load_en, 0);
                chk(reload_value == val, "R2 R5 load", reload_value, val);
            end
        end
        exp_reload = val;
        repeat (3) begin
            @(negedge clk);
            chk(load_en == 1'b0, "R4 quiet", load_en, 0);
        end
    endtask

    initial begin
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(load_en == 1'b0, "R8 enable", load_en, 0);
        chk(reload_value == 8'h00, "R8 reload", reload_value, 0);
        chk(count_value == 8'h00, "R8 count", count_value, 0);
        rst = 1'b0;
        mon_on = 1'b1;

        // Sweep every byte value, MSB first.
        for (int v = 0; v < 256; v++) begin
            spi_send(16'(v), 8);
            expect_transfer(8'(v));
        end

        // More than eight bits: last eight remain (R2).
        spi_send(16'hC35A, 16);
        expect_transfer(8'h5A);
        spi_send(16'h0F81, 12);
        expect_transfer(8'h81);

        // R1: clocks with chip select high are ignored.
        spi_send(16'h00A5, 8);
        expect_transfer(8'hA5);
        #9;
        for (int i = 0; i < 8; i++) begin
            spi_mosi = ~spi_mosi;
            #20 spi_sclk = 1'b1;
            #20 spi_sclk = 1'b0;
        end
        spi_send(16'h0000, 0);
        expect_transfer(8'hA5);
        chk(reload_value == 8'hA5, "R1 ignored", reload_value, 8'hA5);

        // Let the counter wrap several times with a known reload value.
        repeat (700) @(negedge clk);

        // R8: reset in the middle of operation.
        mon_on = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(reload_value == 8'h00, "R8 reload mid", reload_value, 0);
        chk(count_value == 8'h00, "R8 count mid", count_value, 0);
        chk(load_en == 1'b0, "R8 enable mid", load_en, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule